// File: doc/BRIEF.md
# Watchdog Safety Output Controller

This block drives a parallel digital-output port and guards it with a down-counting watchdog. The host writes output values on a data port. It writes the watchdog timeout, a safe pattern and a power-up default pattern on three further write ports. A 16-bit write-only control word arms the watchdog, clears its interrupt, enables the safety override and selects what a warm reset does to the outputs. The counter decrements on each single-cycle `tick`. When it runs out, the block raises `irq`. If the safety override is enabled, the port then switches to the safe pattern until the interrupt is cleared.

There are two reset inputs. The cold reset, `por_n`, is an asynchronous active-low power-on reset, and it always loads the default outputs. The warm reset, `warm_rst`, is a synchronous pulse. It stops the watchdog and drops the interrupt. It then either keeps the present outputs or reloads the default pattern, depending on the hold-enable bit. That bit itself survives a warm reset.

The watchdog is a three-state machine:
- `WD_IDLE`: the watchdog is disarmed and the counter tracks the timeout register.
- `WD_RUN`: the counter decrements on each tick.
- `WD_EXPIRED`: the counter is parked at zero and `irq` is high.

Its transitions are:
- **arm**: IDLE to RUN, on a control write with the enable bit set.
- **expire**: RUN to EXPIRED, on a tick while the count is 1 or less.
- **clear**: EXPIRED or RUN to RUN, on a control write with both the enable bit and the clear bit set.
- **disarm**: any state to IDLE, on a control write with the enable bit at 0.
- **warm**: any state to IDLE, on `warm_rst`.

Top module: `wdso_top`

## Requirements
- R1: While `por_n` is low and after it rises, `irq` is 0 and `dout` equals `DEF_DOUT`. The default, safe and timeout registers take `DEF_DOUT`, `SAFE_INIT` and `DEF_TMO`. The hold and safety enables read as 0. All of this holds whatever was programmed before.
- R2: A write on `dout_we` appears on `dout` in the next cycle, unless the safety override is active.
- R3: Writing control bit 1 as 1 arms the watchdog from the timeout register. Each `tick` in RUN decrements the count. `irq` rises in the cycle after the tick that meets a count of 1 or 0. `irq` then stays high, and the count stays at zero, for any number of further ticks.
- R4: While the watchdog is disarmed, `tick` has no effect and `irq` stays 0.
- R5: A control write with bits 1 and 2 both set drops `irq` in the next cycle and restarts the count from the timeout register. The clear bit is not stored.
- R6: A control write with bit 1 at 0 disarms the watchdog and drops `irq` in the next cycle.
- R7: Control bit 3 is the safety enable. While it is 1 and `irq` is high, `dout` shows the safe pattern. Once `irq` falls, `dout` shows the last host-written value, including any value written during the override.
- R8: Control bit 0 is the hold enable. A `warm_rst` cycle with hold at 1 leaves the host output value unchanged. The hold bit is kept across the warm reset.
- R9: A `warm_rst` cycle with hold at 0 loads the default-pattern register into the host output value.
- R10: `warm_rst` disarms the watchdog and drops `irq` in the next cycle. In that cycle it takes priority over a control write or an output write, both of which are ignored.
- R11: Control bits 15 to 4 are ignored.
- R12: A timeout write takes effect at the next reload (arm, clear, disarm or warm reset), not on a count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-on reset, asynchronous, active low |
| warm_rst | input | 1 | Warm reset pulse, synchronous, active high |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word: bit0 hold, bit1 arm, bit2 clear, bit3 safety |
| tmo_we | input | 1 | Timeout write strobe |
| tmo_wdata | input | CW | Timeout reload value |
| safe_we | input | 1 | Safe pattern write strobe |
| safe_wdata | input | DW | Safe pattern |
| dflt_we | input | 1 | Default pattern write strobe |
| dflt_wdata | input | DW | Power-up default pattern |
| dout_we | input | 1 | Host output write strobe |
| dout_wdata | input | DW | Host output value |
| tick | input | 1 | Count-down tick, one cycle wide |
| irq | output | 1 | Watchdog interrupt |
| dout | output | DW | Digital output port |

## Verification
The bench builds the block with an 8-bit output port, a 4-bit counter and a default timeout of 5. These values let expiry, re-expiry after a clear and a timeout of zero all happen within a few dozen cycles. The 4-bit counter makes both the largest reachable timeout and the no-wrap parking at zero short to reach. The distinct default, safe and host patterns make any mix-up between the three sources visible on `dout`.

// File: rtl/wdso_pkg.sv
package wdso_pkg;
    typedef enum logic [1:0] {
        WD_IDLE     = 2'd0,
        WD_RUN      = 2'd1,
        WD_EXPIRED  = 2'd2
    } wd_state_e;

    localparam int unsigned CTRL_W     = 16;
    localparam int unsigned BIT_HOLD   = 0;
    localparam int unsigned BIT_ARM    = 1;
    localparam int unsigned BIT_CLEAR  = 2;
    localparam int unsigned BIT_SAFETY = 3;
endpackage

// File: rtl/wdso_cfg.sv
module wdso_cfg
    import wdso_pkg::*;
#(
    parameter int unsigned     DW        = 16,
    parameter int unsigned     CW        = 16,
    parameter int unsigned     DEF_TMO   = 1000,
    parameter logic [DW-1:0]   DEF_DOUT  = '0,
    parameter logic [DW-1:0]   SAFE_INIT = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tmo_we,
    input  logic [CW-1:0]     tmo_wdata,
    input  logic              safe_we,
    input  logic [DW-1:0]     safe_wdata,
    input  logic              dflt_we,
    input  logic [DW-1:0]     dflt_wdata,
    output logic              cfg_wr,
    output logic              cfg_arm,
    output logic              cfg_clr,
    output logic              hold_en,
    output logic              safety_en,
    output logic [CW-1:0]     tmo_q,
    output logic [DW-1:0]     safe_q,
    output logic [DW-1:0]     dflt_q
);
    // A control write is dropped in a warm-reset cycle.
    assign cfg_wr  = ctrl_we && !warm_rst;
    assign cfg_arm = ctrl_wdata[BIT_ARM];
    assign cfg_clr = ctrl_wdata[BIT_CLEAR];

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            hold_en   <= 1'b0;
            safety_en <= 1'b0;
        end else if (cfg_wr) begin
            hold_en   <= ctrl_wdata[BIT_HOLD];
            safety_en <= ctrl_wdata[BIT_SAFETY];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmo_q  <= CW'(DEF_TMO);
            safe_q <= SAFE_INIT;
            dflt_q <= DEF_DOUT;
        end else begin
            if (tmo_we)  tmo_q  <= tmo_wdata;
            if (safe_we) safe_q <= safe_wdata;
            if (dflt_we) dflt_q <= dflt_wdata;
        end
    end

    // R8
    hold_survives_warm_chk: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst) |=> (hold_en == $past(hold_en)));
endmodule

// File: rtl/wdso_timer.sv
module wdso_timer
    import wdso_pkg::*;
#(
    parameter int unsigned CW      = 16,
    parameter int unsigned DEF_TMO = 1000
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_rst,
    input  logic          cfg_wr,
    input  logic          cfg_arm,
    input  logic          cfg_clr,
    input  logic          tick,
    input  logic [CW-1:0] tmo_q,
    output logic          irq
);
    wd_state_e     st, st_n;
    logic [CW-1:0] cnt, cnt_n;

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (warm_rst) begin
            st_n  = WD_IDLE;
            cnt_n = tmo_q;
        end else if (cfg_wr) begin
            if (!cfg_arm) begin
                st_n  = WD_IDLE;
                cnt_n = tmo_q;
            end else if (cfg_clr || st == WD_IDLE) begin
                st_n  = WD_RUN;
                cnt_n = tmo_q;
            end
        end else begin
            unique case (st)
                WD_IDLE: cnt_n = tmo_q;
                WD_RUN: begin
                    if (tick) begin
                        if (cnt <= CW'(1)) begin
                            cnt_n = '0;
                            st_n  = WD_EXPIRED;
                        end else begin
                            cnt_n = cnt - CW'(1);
                        end
                    end
                end
                WD_EXPIRED: cnt_n = '0;
                default: st_n = WD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st  <= WD_IDLE;
            cnt <= CW'(DEF_TMO);
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        irq = (st == WD_EXPIRED);
    end

    // R3
    tick_decrements_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st == WD_RUN && tick && !warm_rst && !cfg_wr && cnt > CW'(1))
        |=> (cnt == $past(cnt) - CW'(1) && !irq));
    // R3
    expired_parks_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st == WD_EXPIRED && !warm_rst && !cfg_wr) |=> (irq && cnt == '0));
    // R5
    clear_reloads_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_wr && cfg_arm && cfg_clr) |=> (!irq && cnt == $past(tmo_q)));
    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        (st == WD_IDLE && !cfg_wr) |=> !irq);
    // R10
    warm_disarms_chk: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst) |=> (!irq && st == WD_IDLE));
endmodule

// File: rtl/wdso_outmux.sv
module wdso_outmux #(
    parameter int unsigned   DW       = 16,
    parameter logic [DW-1:0] DEF_DOUT = '0
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_rst,
    input  logic          hold_en,
    input  logic          safety_en,
    input  logic          irq,
    input  logic          dout_we,
    input  logic [DW-1:0] dout_wdata,
    input  logic [DW-1:0] safe_q,
    input  logic [DW-1:0] dflt_q,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] live_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            live_q <= DEF_DOUT;
        end else if (warm_rst) begin
            if (!hold_en) live_q <= dflt_q;
        end else if (dout_we) begin
            live_q <= dout_wdata;
        end
    end

    always_comb begin
        dout = (safety_en && irq) ? safe_q : live_q;
    end

    // R8
    warm_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst && hold_en) |=> (live_q == $past(live_q)));
    // R9
    warm_default_chk: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst && !hold_en) |=> (live_q == $past(dflt_q)));
endmodule

// File: rtl/wdso_top.sv
module wdso_top
    import wdso_pkg::*;
#(
    parameter int unsigned   DW        = 16,
    parameter int unsigned   CW        = 16,
    parameter int unsigned   DEF_TMO   = 1000,
    parameter logic [DW-1:0] DEF_DOUT  = '0,
    parameter logic [DW-1:0] SAFE_INIT = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              warm_rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              tmo_we,
    input  logic [CW-1:0]     tmo_wdata,
    input  logic              safe_we,
    input  logic [DW-1:0]     safe_wdata,
    input  logic              dflt_we,
    input  logic [DW-1:0]     dflt_wdata,
    input  logic              dout_we,
    input  logic [DW-1:0]     dout_wdata,
    input  logic              tick,
    output logic              irq,
    output logic [DW-1:0]     dout
);
    logic          cfg_wr, cfg_arm, cfg_clr, hold_en, safety_en;
    logic [CW-1:0] tmo_q;
    logic [DW-1:0] safe_q, dflt_q;

    wdso_cfg #(
        .DW(DW), .CW(CW), .DEF_TMO(DEF_TMO), .DEF_DOUT(DEF_DOUT), .SAFE_INIT(SAFE_INIT)
    ) u_cfg (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
        .safe_we(safe_we), .safe_wdata(safe_wdata),
        .dflt_we(dflt_we), .dflt_wdata(dflt_wdata),
        .cfg_wr(cfg_wr), .cfg_arm(cfg_arm), .cfg_clr(cfg_clr),
        .hold_en(hold_en), .safety_en(safety_en),
        .tmo_q(tmo_q), .safe_q(safe_q), .dflt_q(dflt_q)
    );

    wdso_timer #(.CW(CW), .DEF_TMO(DEF_TMO)) u_timer (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .cfg_wr(cfg_wr), .cfg_arm(cfg_arm), .cfg_clr(cfg_clr),
        .tick(tick), .tmo_q(tmo_q), .irq(irq)
    );

    wdso_outmux #(.DW(DW), .DEF_DOUT(DEF_DOUT)) u_out (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .hold_en(hold_en), .safety_en(safety_en), .irq(irq),
        .dout_we(dout_we), .dout_wdata(dout_wdata),
        .safe_q(safe_q), .dflt_q(dflt_q), .dout(dout)
    );

    // R6
    disarm_drops_chk: assert property (@(posedge clk) disable iff (!por_n)
        (ctrl_we && !warm_rst && !ctrl_wdata[BIT_ARM]) |=> !irq);
endmodule

// File: tb/sim_wdso_top.sv
module sim_wdso_top;
    localparam int unsigned   DW = 8;
    localparam int unsigned   CW = 4;
    localparam int unsigned   TMO0 = 5;
    localparam logic [DW-1:0] DEFV = 8'hA5;
    localparam logic [DW-1:0] SAFEV = 8'h00;

    logic clk = 1'b0;
    logic por_n = 1'b0, warm_rst = 1'b0, ctrl_we = 1'b0, tmo_we = 1'b0;
    logic safe_we = 1'b0, dflt_we = 1'b0, dout_we = 1'b0, tick = 1'b0;
    logic [15:0]   ctrl_wdata = '0;
    logic [CW-1:0] tmo_wdata = '0;
    logic [DW-1:0] safe_wdata = '0, dflt_wdata = '0, dout_wdata = '0;
    logic          irq;
    logic [DW-1:0] dout;

    always #2 clk = ~clk;

    wdso_top #(.DW(DW), .CW(CW), .DEF_TMO(TMO0), .DEF_DOUT(DEFV), .SAFE_INIT(SAFEV)) u0 (
        .clk(clk), .por_n(por_n), .warm_rst(warm_rst),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .tmo_we(tmo_we), .tmo_wdata(tmo_wdata),
        .safe_we(safe_we), .safe_wdata(safe_wdata),
        .dflt_we(dflt_we), .dflt_wdata(dflt_wdata),
        .dout_we(dout_we), .dout_wdata(dout_wdata),
        .tick(tick), .irq(irq), .dout(dout)
    );

    // reference model state
    int   m_state;       // 0 disarmed, 1 counting, 2 expired
    int   m_cnt, m_tmo;
    bit   m_hold, m_safe_en;
    logic [DW-1:0] m_live, m_safe, m_dflt;
    int   n_vec = 0, n_bad = 0;
    bit   done = 1'b0;
    string req = "R1";

    task automatic model_cold();
        m_state = 0; m_tmo = TMO0; m_cnt = TMO0;
        m_hold = 0; m_safe_en = 0;
        m_live = DEFV; m_safe = SAFEV; m_dflt = DEFV;
    endtask

    task automatic model_step();
        int old_tmo = m_tmo;
        if (warm_rst) begin
            m_state = 0; m_cnt = old_tmo;
            if (!m_hold) m_live = m_dflt;
        end else begin
            if (ctrl_we) begin
                m_hold    = ctrl_wdata[0];
                m_safe_en = ctrl_wdata[3];
                if (!ctrl_wdata[1]) begin
                    m_state = 0; m_cnt = old_tmo;
                end else if (ctrl_wdata[2] || m_state == 0) begin
                    m_state = 1; m_cnt = old_tmo;
                end
            end else if (m_state == 1 && tick) begin
                if (m_cnt <= 1) begin m_cnt = 0; m_state = 2; end
                else m_cnt = m_cnt - 1;
            end else if (m_state == 0) begin
                m_cnt = old_tmo;
            end
            if (dout_we) m_live = dout_wdata;
        end
        if (tmo_we)  m_tmo  = int'(tmo_wdata);
        if (safe_we) m_safe = safe_wdata;
        if (dflt_we) m_dflt = dflt_wdata;
    endtask

    task automatic compare();
        logic          e_irq = (m_state == 2);
        logic [DW-1:0] e_dout = (m_safe_en && e_irq) ? m_safe : m_live;
        n_vec++;
        if (irq !== e_irq) begin
            n_bad++;
            $display("FAIL %s irq actual=%b expected=%b at %0t", req, irq, e_irq, $time);
        end
        if (dout !== e_dout) begin
            n_bad++;
            $display("FAIL %s dout actual=%h expected=%h at %0t", req, dout, e_dout, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
        warm_rst = 0; ctrl_we = 0; tmo_we = 0; safe_we = 0;
        dflt_we = 0; dout_we = 0; tick = 0;
    endtask

    task automatic cold();
        @(negedge clk);
        por_n = 0;
        model_cold();
        #1 compare();
        @(negedge clk);
        compare();
        por_n = 1;
        cyc();
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        ctrl_we = 1; ctrl_wdata = v; cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; cyc();
            cyc();
        end
    endtask

    initial begin
        model_cold();
        req = "R1"; cold();
        req = "R2"; dout_we = 1; dout_wdata = 8'h3C; cyc(); cyc();
        req = "R4"; ticks(8);
        req = "R12"; tmo_we = 1; tmo_wdata = 4'd4; cyc();
        req = "R3"; wr_ctrl(16'h0002); ticks(3); ticks(1); ticks(20);
        req = "R5"; wr_ctrl(16'h0006); ticks(2);
        req = "R12"; tmo_we = 1; tmo_wdata = 4'd2; cyc(); ticks(2);
        req = "R5"; wr_ctrl(16'h0006); ticks(2);
        req = "R6"; wr_ctrl(16'h0000); ticks(4);
        req = "R3"; tmo_we = 1; tmo_wdata = 4'd0; cyc(); wr_ctrl(16'h0002); ticks(1);
        tmo_we = 1; tmo_wdata = 4'd15; cyc(); wr_ctrl(16'h0006); ticks(17);
        req = "R7"; safe_we = 1; safe_wdata = 8'h81; cyc();
        tmo_we = 1; tmo_wdata = 4'd3; cyc();
        wr_ctrl(16'h000A); ticks(3);
        dout_we = 1; dout_wdata = 8'h55; cyc(); cyc();
        wr_ctrl(16'h000E); ticks(1);
        req = "R11"; wr_ctrl(16'hFFF0); ticks(4);
        wr_ctrl(16'hFFF2); ticks(3);
        wr_ctrl(16'h5AF0); cyc();
        req = "R8"; dflt_we = 1; dflt_wdata = 8'h0F; cyc();
        dout_we = 1; dout_wdata = 8'h66; cyc();
        wr_ctrl(16'h0001); warm_rst = 1; cyc(); cyc();
        warm_rst = 1; cyc(); cyc();
        req = "R9"; wr_ctrl(16'h0000); warm_rst = 1; cyc(); cyc();
        req = "R10"; wr_ctrl(16'h000B); ticks(3);
        warm_rst = 1; ctrl_we = 1; ctrl_wdata = 16'h0006; dout_we = 1; dout_wdata = 8'hEE; cyc();
        ticks(5);
        wr_ctrl(16'h0002); warm_rst = 1; cyc(); ticks(4);
        req = "R1"; wr_ctrl(16'h000B); dflt_we = 1; dflt_wdata = 8'h11; cyc(); ticks(3);
        cold(); warm_rst = 1; cyc(); cyc();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule